// File: doc/BRIEF.md
# Wide-Operand Serial Adder Peripheral

This block is a memory-mapped slave. It lets a processor with a 32-bit data path add two very wide unsigned integers. Software stores both operands one data word at a time, and byte enables choose which lanes of the addressed word change. Software then writes a start bit and polls a status word. When the done flag rises, it reads back the sum, also one word at a time, together with a separate carry-out flag.

Inside, the two operands sit in word-organised register files. A single word-wide adder stage handles one word slice per clock, from the least significant word upward, and passes the carry from each slice to the next. A full addition therefore takes `NUM_WORDS` cycles. Reads have a fixed latency of one cycle: the data appears on the clock after the read strobe and holds until the next read. Both `NUM_WORDS` (32 by default, giving 1024-bit numbers) and `DATA_W` (32) are parameters.

The word map places operand A at word addresses `0..N-1`, operand B at `N..2N-1` and the sum at `2N..3N-1`, where N is `NUM_WORDS`. The control/status word sits at `3N`.

Top module: `wadd_top`

## Requirements
- R1: A write to word address k (k < N) stores into word k of operand A. A write to address N+k stores into word k of operand B. A read of either address returns the stored word.
- R2: On a write, `byteenable_i[j]` selects data bits `8j+7:8j`. Only the enabled lanes of the addressed word change.
- R3: After an addition completes, address 2N+k returns word k of (A + B) mod 2^(N·DATA_W). Writes to the sum addresses change nothing.
- R4: Status bit 3 holds the carry-out of A + B once the addition is done.
- R5: A write to address 3N with `byteenable_i[0]`=1 and data bit 0 = 1 starts an addition. Start clears done and carry. Bit 0 always reads back as 0.
- R6: Status bit 1 (busy) reads 1 for exactly N consecutive cycles after the start edge. Busy then falls and status bit 2 (done) is set in the same edge. Busy and done are never both 1.
- R7: Operand writes and start requests made while busy is 1 are ignored.
- R8: `readdata_o` is loaded on the clock edge at which `read_i` is 1, from the state before that edge, and holds while `read_i` is 0. Addresses above 3N read as 0.
- R9: Asserting `rst_ni` low clears both operands, the sum, busy, done and carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| write_i | input | 1 | Write strobe |
| writedata_i | input | DATA_W | Write data |
| byteenable_i | input | DATA_W/8 | Byte lane enables for writes |
| read_i | input | 1 | Read strobe |
| readdata_o | output | DATA_W | Registered read data, one-cycle latency |

## Verification
The bench builds the block with `NUM_WORDS` = 4 and `DATA_W` = 32, which gives 128-bit operands and places the control word at address 12. With this size, an all-ones plus one addition carries through every word slice into the carry-out in a few cycles. It also lets the bench poll the busy window cycle by cycle and run several random operand pairs cheaply. The behavioural model adds whole 128-bit values at once and checks `readdata_o` on every clock, so any error in slice order or carry hand-over shows up as a wrong word or a wrong carry flag.

// File: rtl/wadd_pkg.sv
package wadd_pkg;
  localparam int CTRL_START = 0;
  localparam int ST_BUSY    = 1;
  localparam int ST_DONE    = 2;
  localparam int ST_CARRY   = 3;
endpackage

// File: rtl/wadd_opnd_regs.sv
module wadd_opnd_regs #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 32,
  parameter int IDX_W     = 5,
  localparam int BE_W     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [DATA_W-1:0] a_o [NUM_WORDS],
  output logic [DATA_W-1:0] b_o [NUM_WORDS]
);
  logic [DATA_W-1:0] a_q [NUM_WORDS];
  logic [DATA_W-1:0] b_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        a_q[w] <= '0;
        b_q[w] <= '0;
      end
    end else if (!busy_i && (wr_a_i || wr_b_i)) begin
      for (int l = 0; l < BE_W; l++) begin
        if (be_i[l]) begin
          if (wr_a_i) a_q[idx_i][l*8 +: 8] <= wdata_i[l*8 +: 8];
          if (wr_b_i) b_q[idx_i][l*8 +: 8] <= wdata_i[l*8 +: 8];
        end
      end
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_hold
    AST_OPND_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i |=> ($stable(a_q[w]) && $stable(b_q[w]))); // R7
  end
endmodule

// File: rtl/wadd_engine.sv
module wadd_engine
  import wadd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 32,
  parameter int IDX_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] a_i [NUM_WORDS],
  input  logic [DATA_W-1:0] b_i [NUM_WORDS],
  output logic [DATA_W-1:0] sum_o [NUM_WORDS],
  output logic              busy_o,
  output logic              done_o,
  output logic              carry_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [DATA_W-1:0] sum_q [NUM_WORDS];
  logic [IDX_W-1:0]  idx_q;
  logic              chain_q, busy_q, done_q, carry_q;
  logic [DATA_W:0]   stage;

  // one word slice per cycle, carry handed to the next slice
  always_comb stage = {1'b0, a_i[idx_q]} + {1'b0, b_i[idx_q]} + (DATA_W+1)'(chain_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WORDS; w++) sum_q[w] <= '0;
      idx_q   <= '0;
      chain_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      carry_q <= 1'b0;
    end else if (busy_q) begin
      sum_q[idx_q] <= stage[DATA_W-1:0];
      chain_q      <= stage[DATA_W];
      if (idx_q == LAST_IDX) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        carry_q <= stage[DATA_W];
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end else if (start_i) begin
      idx_q   <= '0;
      chain_q <= 1'b0;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      carry_q <= 1'b0;
    end
  end

  assign sum_o   = sum_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign carry_o = carry_q;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && done_q)); // R6
  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && !done_q && !carry_q)); // R5
  AST_LAST_SLICE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q == LAST_IDX) |=> (!busy_q && done_q)); // R6
  AST_FALL_MEANS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q); // R6

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sum_hold
    AST_SUM_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q |=> $stable(sum_q[w])); // R3
  end
endmodule

// File: rtl/wadd_top.sv
module wadd_top
  import wadd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 32,
  localparam int ADDR_W   = $clog2(3 * NUM_WORDS + 1),
  localparam int BE_W     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] writedata_i,
  input  logic [BE_W-1:0]   byteenable_i,
  input  logic              read_i,
  output logic [DATA_W-1:0] readdata_o
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [ADDR_W-1:0] BASE_B   = ADDR_W'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] BASE_S   = ADDR_W'(2 * NUM_WORDS);
  localparam logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'(3 * NUM_WORDS);

  logic              in_a, in_b, in_s, is_ctrl, start;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] a_w   [NUM_WORDS];
  logic [DATA_W-1:0] b_w   [NUM_WORDS];
  logic [DATA_W-1:0] sum_w [NUM_WORDS];
  logic              busy, done, carry;
  logic [DATA_W-1:0] status, rd_mux, rdata_q;

  always_comb begin
    in_a    = addr_i < BASE_B;
    in_b    = (addr_i >= BASE_B) && (addr_i < BASE_S);
    in_s    = (addr_i >= BASE_S) && (addr_i < CTRL_ADR);
    is_ctrl = addr_i == CTRL_ADR;
    if (in_a)      idx = IDX_W'(addr_i);
    else if (in_b) idx = IDX_W'(addr_i - BASE_B);
    else           idx = IDX_W'(addr_i - BASE_S);
    start = write_i && is_ctrl && byteenable_i[0] && writedata_i[CTRL_START];
  end

  wadd_opnd_regs #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy),
    .wr_a_i (write_i && in_a),
    .wr_b_i (write_i && in_b),
    .idx_i  (idx),
    .wdata_i(writedata_i),
    .be_i   (byteenable_i),
    .a_o    (a_w),
    .b_o    (b_w)
  );

  wadd_engine #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .a_i    (a_w),
    .b_i    (b_w),
    .sum_o  (sum_w),
    .busy_o (busy),
    .done_o (done),
    .carry_o(carry)
  );

  always_comb begin
    status           = '0;
    status[ST_BUSY]  = busy;
    status[ST_DONE]  = done;
    status[ST_CARRY] = carry;
    if (in_a)         rd_mux = a_w[idx];
    else if (in_b)    rd_mux = b_w[idx];
    else if (in_s)    rd_mux = sum_w[idx];
    else if (is_ctrl) rd_mux = status;
    else              rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (read_i) rdata_q <= rd_mux;
  end

  assign readdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_i |=> $stable(readdata_o)); // R8
  AST_START_BIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && is_ctrl) |=> !readdata_o[CTRL_START]); // R5
endmodule

// File: tb/tb_wadd_top.sv
`timescale 1ns/1ps
module tb_wadd_top;
  localparam int W  = 32;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int CTRL = 3 * N;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [W-1:0]  wdata = '0;
  logic [3:0]    be = '0;
  logic [W-1:0]  rdata;

  int errors = 0, checks = 0;

  logic [W-1:0]   ma [N];
  logic [W-1:0]   mb [N];
  logic [W-1:0]   ms [N];
  logic [N*W:0]   mres;
  logic           mbusy, mdone, mcar;
  int             mstep;
  logic [W-1:0]   rd_exp;

  always #2.5 clk = ~clk;

  wadd_top #(.DATA_W(W), .NUM_WORDS(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .write_i(wr),
    .writedata_i(wdata), .byteenable_i(be), .read_i(rd), .readdata_o(rdata)
  );

  task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin ma[i] = '0; mb[i] = '0; ms[i] = '0; end
    mbusy = 0; mdone = 0; mcar = 0; mstep = 0; rd_exp = '0; mres = '0;
  endtask

  function automatic logic [W-1:0] model_read(input int a);
    if (a < N)          return ma[a];
    else if (a < 2*N)   return mb[a-N];
    else if (a < 3*N)   return ms[a-2*N];
    else if (a == CTRL) return W'({mcar, mdone, mbusy, 1'b0});
    else                return '0;
  endfunction

  function automatic string req_of(input int a);
    if (a < 2*N)        return "R1";
    else if (a < 3*N)   return "R3";
    else if (a == CTRL) return "R6";
    else                return "R8";
  endfunction

  // one bus cycle: drive at negedge, advance model at posedge, compare at next negedge
  task automatic cyc(input logic w, input logic r, input int a,
                     input logic [W-1:0] d, input logic [3:0] b, input string tag);
    logic [N*W-1:0] fa, fb;
    wr = w; rd = r; addr = AW'(a); wdata = d; be = b;
    @(posedge clk);
    if (r) rd_exp = model_read(a);
    if (mbusy) begin
      ms[mstep] = mres[mstep*W +: W];
      mstep++;
      if (mstep == N) begin mbusy = 0; mdone = 1; mcar = mres[N*W]; end
    end else if (w) begin
      for (int l = 0; l < 4; l++) if (b[l]) begin
        if (a < N)        ma[a][l*8 +: 8]   = d[l*8 +: 8];
        else if (a < 2*N) mb[a-N][l*8 +: 8] = d[l*8 +: 8];
      end
      if (a == CTRL && b[0] && d[0]) begin
        for (int i = 0; i < N; i++) begin fa[i*W +: W] = ma[i]; fb[i*W +: W] = mb[i]; end
        mres = {1'b0, fa} + {1'b0, fb};
        mbusy = 1; mdone = 0; mcar = 0; mstep = 0;
      end
    end
    @(negedge clk);
    check(rdata === rd_exp, (tag == "") ? (r ? req_of(a) : "R8") : tag, rdata, rd_exp);
    wr = 0; rd = 0; be = '0;
  endtask

  task automatic wrw(input int a, input logic [W-1:0] d, input logic [3:0] b, input string t);
    cyc(1'b1, 1'b0, a, d, b, t);
  endtask
  task automatic rdw(input int a, input string t); cyc(1'b0, 1'b1, a, '0, '0, t); endtask

  task automatic load(input logic [N*W-1:0] a, input logic [N*W-1:0] b);
    for (int i = 0; i < N; i++) wrw(i, a[i*W +: W], 4'hf, "R1");
    for (int i = 0; i < N; i++) wrw(N + i, b[i*W +: W], 4'hf, "R1");
  endtask

  // start, poll status, count busy reads (R6), then read sum and carry
  task automatic run_add(input string tag);
    int busy_seen = 0;
    wrw(CTRL, 32'h1, 4'h1, "R5");
    for (int k = 0; k < 3*N; k++) begin
      rdw(CTRL, "R6");
      if (rdata[1]) busy_seen++;
      if (rdata[2]) break;
    end
    check(busy_seen == N, "R6", W'(busy_seen), W'(N));
    for (int i = 0; i < N; i++) rdw(2*N + i, tag);
    rdw(CTRL, "R4");
    check(rdata[0] == 1'b0, "R5", rdata, rdata & ~32'h1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; model_clear();
    repeat (2) @(negedge clk);
    check(rdata === '0, "R9", rdata, '0);
    rst_ni = 1;
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R9/R8: everything zero after reset, unmapped reads 0
    for (int a = 0; a < 16; a++) rdw(a, (a > CTRL) ? "R8" : "R9");
    // R1: full-word writes and readback
    load({32'h0123_4567, 32'h89ab_cdef, 32'h0f0f_0f0f, 32'hdead_beef},
         {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888});
    for (int a = 0; a < 2*N; a++) rdw(a, "R1");
    // R2: byte-lane masking
    wrw(1, 32'haabb_ccdd, 4'b0101, "R2"); rdw(1, "R2");
    wrw(N + 2, 32'h1122_3344, 4'b1000, "R2"); rdw(N + 2, "R2");
    wrw(3, 32'hffff_ffff, 4'b0000, "R2"); rdw(3, "R2");
    // R8: readdata holds across idle cycles
    rdw(0, "R8"); cyc(0, 0, 5, '0, '0, "R8"); cyc(0, 0, 7, '0, '0, "R8");
    run_add("R3");
    // R3: sum region read-only
    wrw(2*N, 32'h5a5a_5a5a, 4'hf, "R3"); rdw(2*N, "R3");
    // R7: writes and start while busy are ignored
    wrw(CTRL, 32'h1, 4'hf, "R5");
    wrw(0, 32'hcafe_f00d, 4'hf, "R7");
    wrw(N, 32'hbead_0000, 4'hf, "R7");
    wrw(CTRL, 32'h1, 4'hf, "R7");
    rdw(CTRL, "R7"); rdw(CTRL, "R7");
    repeat (N) rdw(CTRL, "R6");
    rdw(0, "R7"); rdw(N, "R7");
    // R5: start needs byte lane 0
    wrw(CTRL, 32'h1, 4'b1110, "R5"); rdw(CTRL, "R5");
    // R4: full carry ripple, all ones + 1
    load({N*W{1'b1}}, (N*W)'(1));
    run_add("R4");
    // R4: all ones + 0, no carry
    load({N*W{1'b1}}, '0);
    run_add("R4");
    // R3: random operands
    for (int t = 0; t < 6; t++) begin
      logic [N*W-1:0] ra, rb;
      for (int i = 0; i < N; i++) begin ra[i*W +: W] = $urandom; rb[i*W +: W] = $urandom; end
      load(ra, rb);
      run_add("R3");
    end
    // R9: reset mid-operation clears state
    wrw(CTRL, 32'h1, 4'h1, "R5");
    rdw(CTRL, "R6");
    do_reset();
    for (int a = 0; a <= CTRL; a++) rdw(a, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule